// File: doc/BRIEF.md
# Century Rollover Detector with Power-State Gated Interrupt

This block watches a BCD year register and spots the moment the year wraps from 99 back to 00. Every time software or the time-keeping logic updates the year, it raises an update strobe together with the new value. The block keeps its own copy of the year that was last written and compares it with the incoming value. A wrap sets a sticky new-century status flag.

A wrap can also raise a one-cycle system-management interrupt pulse, but only while the power-state input reports the full-run state. In the sleep states the flag is still set, and no pulse is sent. Firmware that resumes later reads the flag, corrects the century value held elsewhere, and clears the flag by writing a one to it. The block does not hold or update the century register itself.

Top module: `century_wrap_detect`

## Requirements
- R1: A rollover is an update strobe (`year_we_i`=1) carrying year 8'h00 while the stored year equals 8'h99. The stored year is the value carried by the most recent earlier strobe.
- R2: In the cycle after a rollover strobe, `century_sts_o` reads 1. This holds for every power-state code.
- R3: When a rollover strobe arrives with `pwr_state_i`=2'b00 (full run), `smi_pulse_o` is 1 in the next cycle only, and 0 in the cycle after that.
- R4: When a rollover strobe arrives with `pwr_state_i` set to 2'b01 (light sleep), 2'b10 (deep sleep) or 2'b11 (reserved), `smi_pulse_o` stays 0 and the status flag is still set.
- R5: Once set, `century_sts_o` stays 1 until a clear takes effect, whatever the year strobes and power state do.
- R6: A clear strobe (`sts_wr_i`=1) with `sts_wdata_i`=1 clears `century_sts_o` in the next cycle. A clear strobe with `sts_wdata_i`=0 has no effect.
- R7: If a rollover and a write-one clear arrive in the same cycle, the flag is set afterwards.
- R8: These events raise neither the flag nor the pulse: a strobe with 8'h00 when the stored year is not 8'h99, a strobe with a value other than 8'h00, and any change of `year_i` without a strobe. A year value without a strobe also does not update the stored year.
- R9: After reset, `century_sts_o`=0, `smi_pulse_o`=0, and the stored year is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| year_i | input | 8 | New BCD year value |
| year_we_i | input | 1 | Year update strobe |
| pwr_state_i | input | 2 | Power state: 00 run, 01 light sleep, 10 deep sleep, 11 reserved |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 1 | Write data for the flag; a 1 clears it |
| century_sts_o | output | 1 | Sticky new-century flag |
| smi_pulse_o | output | 1 | One-cycle system-management interrupt |

## Verification
The assertions follow the internal rollover event on every cycle:
- the flag is always set one cycle after the event, and the pulse is present or absent according to the power state;
- the pulse never lasts more than one cycle and never appears without the event;
- the flag holds until a write-one clear, and it stays low when no event occurs.

Some behaviour depends on the history of the year value, and only the bench's scenarios can show it. This covers strobe-less changes of `year_i` leaving the stored year alone, repeated 00 writes, near-miss values such as 98 to 00, and a wrap right after reset. The bench also compares both outputs against a decimal-arithmetic model on every cycle during a long randomised run.

// File: rtl/cen_pkg.sv
package cen_pkg;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_LIGHT = 2'b01,
    PWR_DEEP  = 2'b10,
    PWR_RSVD  = 2'b11
  } pwr_state_e;

  // Only the full-run state may forward the interrupt.
  function automatic logic is_run(input logic [1:0] code);
    return pwr_state_e'(code) == PWR_RUN;
  endfunction

  // Next value of the sticky flag: a set wins over a clear in the same cycle.
  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/cen_year_tracker.sv
module cen_year_tracker #(
  parameter int NDIG = 2,
  localparam int YW = 4 * NDIG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [YW-1:0] year_i,
  input  logic          year_we_i,
  output logic          wrap_o
);

  logic [YW-1:0] last_q;
  logic [YW-1:0] top_year;

  // The largest BCD year: every digit is 9.
  for (genvar g = 0; g < NDIG; g++) begin : g_nines
    assign top_year[4*g +: 4] = 4'h9;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         last_q <= '0;
    else if (year_we_i) last_q <= year_i;
  end

  assign wrap_o = year_we_i && (last_q == top_year) && (year_i == '0);

endmodule

// File: rtl/cen_sts_flag.sv
module cen_sts_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= cen_pkg::next_flag(flag_o, set_i, clr_i);
  end

endmodule

// File: rtl/cen_smi_gen.sv
module cen_smi_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic run_i,
  output logic smi_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) smi_o <= 1'b0;
    else        smi_o <= wrap_i & run_i;
  end

endmodule

// File: rtl/century_wrap_detect.sv
module century_wrap_detect #(
  parameter int NDIG = 2,
  localparam int YEAR_W = 4 * NDIG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [YEAR_W-1:0] year_i,
  input  logic              year_we_i,
  input  logic [1:0]        pwr_state_i,
  input  logic              sts_wr_i,
  input  logic              sts_wdata_i,
  output logic              century_sts_o,
  output logic              smi_pulse_o
);

  // Named internal events, visible to the bound checker.
  logic wrap_evt;
  logic run_now;
  logic clr_evt;

  assign run_now = cen_pkg::is_run(pwr_state_i);
  assign clr_evt = sts_wr_i & sts_wdata_i;

  cen_year_tracker #(.NDIG(NDIG)) trk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .year_i    (year_i),
    .year_we_i (year_we_i),
    .wrap_o    (wrap_evt)
  );

  cen_sts_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wrap_evt),
    .clr_i  (clr_evt),
    .flag_o (century_sts_o)
  );

  cen_smi_gen smi_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap_evt),
    .run_i  (run_now),
    .smi_o  (smi_pulse_o)
  );

endmodule

// File: rtl/century_wrap_detect_chk.sv
module century_wrap_detect_chk #(
  parameter int YEAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [YEAR_W-1:0] year_i,
  input logic              year_we_i,
  input logic              wrap_evt,
  input logic              run_now,
  input logic              clr_evt,
  input logic              sts,
  input logic              smi
);

  a_r1_wrap_needs_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> (year_we_i && year_i == '0));

  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> sts);

  a_r3_smi_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && run_now) |=> smi);

  a_r3_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
    smi |=> !smi);

  a_r4_no_smi_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !run_now) |=> !smi);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr_evt) |=> sts);

  a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !wrap_evt) |=> !sts);

  a_r8_no_smi_without_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> !smi);

  a_r8_flag_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts && !wrap_evt) |=> !sts);

  a_r3_smi_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> sts);

endmodule

bind century_wrap_detect century_wrap_detect_chk #(.YEAR_W(YEAR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .year_i    (year_i),
  .year_we_i (year_we_i),
  .wrap_evt  (wrap_evt),
  .run_now   (run_now),
  .clr_evt   (clr_evt),
  .sts       (century_sts_o),
  .smi       (smi_pulse_o)
);

// File: tb/century_wrap_detect_tb_top.sv
module century_wrap_detect_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] year_i = 8'h00;
  logic       year_we_i = 1'b0;
  logic [1:0] pwr_state_i = 2'b00;
  logic       sts_wr_i = 1'b0;
  logic       sts_wdata_i = 1'b0;
  logic       century_sts_o;
  logic       smi_pulse_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  century_wrap_detect dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .year_i        (year_i),
    .year_we_i     (year_we_i),
    .pwr_state_i   (pwr_state_i),
    .sts_wr_i      (sts_wr_i),
    .sts_wdata_i   (sts_wdata_i),
    .century_sts_o (century_sts_o),
    .smi_pulse_o   (smi_pulse_o)
  );

  // Reference model: years as decimal integers, one update per clock.
  int m_last;
  bit m_sts;
  bit m_smi;

  function automatic int bcd_val(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last = 0; m_sts = 0; m_smi = 0;
    end else begin
      bit roll;
      roll  = year_we_i && m_last == 99 && bcd_val(year_i) == 0;
      m_smi = roll && pwr_state_i == 2'b00;
      if (roll) m_sts = 1;
      else if (sts_wr_i && sts_wdata_i) m_sts = 0;
      if (year_we_i) m_last = bcd_val(year_i);
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison with the model, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(century_sts_o, m_sts, "R5 flag vs model");
      check(smi_pulse_o, m_smi, "R3 pulse vs model");
    end
  end

  // Drive one cycle of inputs; on return the registered result is visible.
  task automatic cyc(input logic we, input logic [7:0] y, input logic [1:0] pw,
                     input logic cw, input logic cd);
    year_we_i = we; year_i = y; pwr_state_i = pw;
    sts_wr_i = cw; sts_wdata_i = cd;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, year_i, pwr_state_i, 1'b0, 1'b0);
  endtask

  task automatic wrap_in(input logic [1:0] pw);
    cyc(1'b1, 8'h99, pw, 1'b0, 1'b0);
    cyc(1'b1, 8'h00, pw, 1'b0, 1'b0);
  endtask

  task automatic clear_flag();
    cyc(1'b0, year_i, pwr_state_i, 1'b1, 1'b1);
  endtask

  task automatic run_main();
    repeat (3) @(negedge clk);
    check(century_sts_o, 1'b0, "R9 flag after reset");
    check(smi_pulse_o, 1'b0, "R9 pulse after reset");
    rst_n = 1'b1;

    // R9: stored year is 00 after reset, so 00 is no wrap
    cyc(1'b1, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R9 stored year 00 after reset");

    // R1/R2/R3: normal wrap in run state
    cyc(1'b1, 8'h45, 2'b00, 1'b0, 1'b0);
    wrap_in(2'b00);
    check(century_sts_o, 1'b1, "R2 flag after wrap");
    check(smi_pulse_o, 1'b1, "R3 pulse after wrap in run");
    idle();
    check(smi_pulse_o, 1'b0, "R3 pulse lasts one cycle");

    // R5: sticky through idle and unrelated strobes
    repeat (5) idle();
    cyc(1'b1, 8'h07, 2'b01, 1'b0, 1'b0);
    check(century_sts_o, 1'b1, "R5 flag held");

    // R6: write 0 ignored, write 1 clears
    cyc(1'b0, 8'h07, 2'b00, 1'b1, 1'b0);
    check(century_sts_o, 1'b1, "R6 write zero ignored");
    clear_flag();
    check(century_sts_o, 1'b0, "R6 write one clears");

    // R8: repeated 00, near misses, strobe-less change
    cyc(1'b1, 8'h00, 2'b00, 1'b0, 1'b0);
    cyc(1'b1, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R8 00 after 00");
    cyc(1'b1, 8'h98, 2'b00, 1'b0, 1'b0);
    cyc(1'b1, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R8 98 to 00");
    cyc(1'b1, 8'h99, 2'b00, 1'b0, 1'b0);
    cyc(1'b1, 8'h01, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R8 99 to 01");
    cyc(1'b1, 8'h50, 2'b00, 1'b0, 1'b0);
    cyc(1'b0, 8'h99, 2'b00, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R8 no strobe no wrap");
    cyc(1'b1, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R8 unstrobed 99 not stored");
    // R1: strobed 99, unstrobed 00, then strobed 00 is a wrap
    cyc(1'b1, 8'h99, 2'b00, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b0, "R8 unstrobed 00 ignored");
    cyc(1'b1, 8'h00, 2'b00, 1'b0, 1'b0);
    check(century_sts_o, 1'b1, "R1 wrap after stored 99");
    check(smi_pulse_o, 1'b1, "R1 pulse after stored 99");
    idle();
    clear_flag();

    // R4: sleep states and reserved code
    for (int p = 1; p < 4; p++) begin
      wrap_in(2'(p));
      check(century_sts_o, 1'b1, $sformatf("R4 flag set in state %0d", p));
      check(smi_pulse_o, 1'b0, $sformatf("R4 no pulse in state %0d", p));
      idle();
      check(smi_pulse_o, 1'b0, "R4 still no pulse");
      clear_flag();
      check(century_sts_o, 1'b0, "R6 clear after sleep wrap");
    end

    // R7: set and clear in the same cycle
    cyc(1'b1, 8'h99, 2'b00, 1'b0, 1'b0);
    cyc(1'b1, 8'h00, 2'b00, 1'b1, 1'b1);
    check(century_sts_o, 1'b1, "R7 set wins over clear");
    check(smi_pulse_o, 1'b1, "R7 pulse with clear");
    clear_flag();

    // Randomised run against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] y;
      int sel;
      sel = $urandom_range(0, 3);
      y = (sel == 0) ? 8'h99 : (sel == 1) ? 8'h00 : 8'($urandom_range(0, 255));
      cyc(1'($urandom_range(0, 1)), y, 2'($urandom_range(0, 3)),
          ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
    end
    idle();
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule